// File: doc/BRIEF.md
# Exclusive Access Reservation Monitor

This block sits between a few requesters and one shared memory port and gives them load-linked / store-conditional semantics. A fixed-priority arbiter takes at most one request per cycle. A requester's exclusive load goes to memory like an ordinary load, and the block also records the 16-byte granule it touched as that requester's reservation.

A later exclusive store from the same requester is checked against that record. If the reservation is still held for the same granule, the store goes to memory and the status is success. If it is not held, nothing is written and the status is failure. In both cases the requester's reservation is dropped.

A write by any other requester to a reserved granule breaks the reservation. This covers ordinary stores and exclusive stores that succeed. The store status reaches the requester on a per-requester valid/ready response channel, one cycle after the store is accepted.

Top module: `excl_resv_monitor`

## Requirements
- R1: An accepted exclusive load (op code 2'b10) appears on the memory port in the same cycle with mem_write=0, the requester's index on mem_id and its address. It also reserves that granule for that requester.
- R2: An exclusive store (op code 2'b11) whose requester holds a reservation on the same granule goes to memory in the same cycle with mem_write=1. Its status is resp_fail=0.
- R3: An exclusive store from a requester that holds no reservation, or holds one on a different granule, gives mem_valid=0 and status resp_fail=1.
- R4: A granule is 16 bytes. Addresses that differ only in bits [3:0] match the same reservation.
- R5: A requester holds at most one reservation. A newer exclusive load replaces the older one, so an exclusive store to the old granule fails.
- R6: Any exclusive store, whether it succeeds or fails, clears the issuing requester's reservation.
- R7: A write to a reserved granule by another requester clears that reservation. Such a write is an ordinary store (op code 2'b01) or a successful exclusive store. Writes to other granules leave the reservation intact.
- R8: Among requests that are allowed to go, the lowest-numbered requester is accepted first. When two exclusive stores to one reserved granule arrive together, the lower index succeeds, the higher index fails, and the failing one reaches no memory.
- R9: resp_valid rises in the cycle after an exclusive store is accepted. It holds with a stable resp_fail until resp_ready. While it is pending, no request from that requester is accepted, and no response is produced for other operations.
- R10: Reset clears every reservation, resp_valid and mem_valid.
- R11: Ordinary loads (op code 2'b00) and stores pass to memory unchanged. A requester's own ordinary store does not clear its reservation. No request is accepted while mem_ready is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, synchronously released |
| req_valid | input | NREQ | Request present, one bit per requester |
| req_op | input | 2*NREQ | Operation per requester: 00 load, 01 store, 10 exclusive load, 11 exclusive store |
| req_addr | input | AW*NREQ | Byte address per requester |
| req_wdata | input | DW*NREQ | Store data per requester |
| req_ready | output | NREQ | Request accepted this cycle |
| mem_valid | output | 1 | Memory access issued |
| mem_write | output | 1 | Access is a write |
| mem_addr | output | AW | Access address |
| mem_wdata | output | DW | Write data |
| mem_id | output | IDW | Index of the requester that owns the access |
| mem_ready | input | 1 | Memory port can take an access |
| resp_valid | output | NREQ | Exclusive store status pending |
| resp_fail | output | NREQ | Status: 0 success, 1 failure |
| resp_ready | input | NREQ | Requester takes the status |

## Verification
The assertions assume that a requester keeps req_valid and its fields steady until req_ready. They also assume that mem_ready reflects whether the memory can take an access in that cycle. The response properties assume each resp_ready is a plain level that the block never has to wait on beyond the pending status. The stimulus drives every request on a falling edge and changes it only after the acceptance edge. It holds resp_ready low only in the dedicated hold test, and it changes mem_ready only between edges while a single request is waiting.

// File: rtl/xm_pkg.sv
package xm_pkg;
  typedef enum logic [1:0] {
    OP_LOAD   = 2'b00,
    OP_STORE  = 2'b01,
    OP_XLOAD  = 2'b10,
    OP_XSTORE = 2'b11
  } xm_op_e;
endpackage

// File: rtl/xm_arbiter.sv
module xm_arbiter #(
  parameter int NREQ = 4,
  localparam int IDW = (NREQ > 1) ? $clog2(NREQ) : 1
) (
  input  logic [NREQ-1:0] req,
  output logic [NREQ-1:0] grant,
  output logic [IDW-1:0]  gid,
  output logic            any
);
  logic [NREQ:0] seen;

  assign seen[0] = 1'b0;

  // lower index wins: each slot is blocked by any request below it
  for (genvar i = 0; i < NREQ; i++) begin : g_prio
    assign seen[i+1] = seen[i] | req[i];
    assign grant[i]  = req[i] & ~seen[i];
  end

  assign any = seen[NREQ];

  always_comb begin
    gid = '0;
    for (int i = 0; i < NREQ; i++) begin
      if (grant[i]) gid = IDW'(i);
    end
  end
endmodule

// File: rtl/xm_resv_table.sv
module xm_resv_table
  import xm_pkg::*;
#(
  parameter int NREQ = 4,
  parameter int TW   = 28,
  localparam int IDW = (NREQ > 1) ? $clog2(NREQ) : 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           acc,
  input  logic [IDW-1:0] gid,
  input  xm_op_e         op,
  input  logic [TW-1:0]  granule,
  output logic           own_hit
);
  logic [NREQ-1:0] v_q, v_d;
  logic [NREQ-1:0] tag_en;
  logic [NREQ-1:0] match;
  logic [TW-1:0]   tag_q [NREQ];
  logic            wr;

  always_comb begin
    own_hit = 1'b0;
    for (int i = 0; i < NREQ; i++) begin
      if (gid == IDW'(i)) own_hit = match[i];
    end
  end

  // a write reaches memory: plain store or passing exclusive store
  assign wr = acc && ((op == OP_STORE) || ((op == OP_XSTORE) && own_hit));

  for (genvar i = 0; i < NREQ; i++) begin : g_slot
    logic own;

    assign match[i]  = v_q[i] && (tag_q[i] == granule);
    assign own       = acc && (gid == IDW'(i));
    assign tag_en[i] = own && (op == OP_XLOAD);

    always_comb begin
      v_d[i] = v_q[i];
      if (tag_en[i]) begin
        v_d[i] = 1'b1;
      end else if (own && (op == OP_XSTORE)) begin
        v_d[i] = 1'b0;
      end else if (wr && !own && match[i]) begin
        v_d[i] = 1'b0;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) v_q[i] <= 1'b0;
      else        v_q[i] <= v_d[i];
    end

    always_ff @(posedge clk) begin
      if (tag_en[i]) tag_q[i] <= granule;
    end

    assert_xload_sets_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (acc && (op == OP_XLOAD) && (gid == IDW'(i)))
      |=> (v_q[i] && (tag_q[i] == $past(granule))));

    assert_xstore_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (acc && (op == OP_XSTORE) && (gid == IDW'(i))) |=> !v_q[i]);

    assert_foreign_write_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (acc && (op == OP_STORE) && (gid != IDW'(i)) && v_q[i] && (tag_q[i] == granule))
      |=> !v_q[i]);
  end
endmodule

// File: rtl/xm_resp.sv
module xm_resp #(
  parameter int NREQ = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NREQ-1:0] set,
  input  logic            set_fail,
  input  logic [NREQ-1:0] resp_ready,
  output logic [NREQ-1:0] resp_valid,
  output logic [NREQ-1:0] resp_fail
);
  logic [NREQ-1:0] v_d;

  for (genvar i = 0; i < NREQ; i++) begin : g_chan
    always_comb begin
      v_d[i] = resp_valid[i] & ~resp_ready[i];
      if (set[i]) v_d[i] = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) resp_valid[i] <= 1'b0;
      else        resp_valid[i] <= v_d[i];
    end

    always_ff @(posedge clk) begin
      if (set[i]) resp_fail[i] <= set_fail;
    end

    assert_resp_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (resp_valid[i] && !resp_ready[i]) |=> (resp_valid[i] && $stable(resp_fail[i])));
  end
endmodule

// File: rtl/excl_resv_monitor.sv
module excl_resv_monitor
  import xm_pkg::*;
#(
  parameter int NREQ = 4,
  parameter int AW   = 32,
  parameter int DW   = 32,
  parameter int GB   = 4,
  localparam int IDW = (NREQ > 1) ? $clog2(NREQ) : 1,
  localparam int TW  = AW - GB
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NREQ-1:0]    req_valid,
  input  logic [2*NREQ-1:0]  req_op,
  input  logic [AW*NREQ-1:0] req_addr,
  input  logic [DW*NREQ-1:0] req_wdata,
  output logic [NREQ-1:0]    req_ready,
  output logic               mem_valid,
  output logic               mem_write,
  output logic [AW-1:0]      mem_addr,
  output logic [DW-1:0]      mem_wdata,
  output logic [IDW-1:0]     mem_id,
  input  logic               mem_ready,
  output logic [NREQ-1:0]    resp_valid,
  output logic [NREQ-1:0]    resp_fail,
  input  logic [NREQ-1:0]    resp_ready
);
  logic [NREQ-1:0] elig;
  logic [NREQ-1:0] grant;
  logic [IDW-1:0]  gid;
  logic            acc;
  xm_op_e          sel_op;
  logic [AW-1:0]   sel_addr;
  logic [DW-1:0]   sel_wdata;
  logic            own_hit;
  logic            is_xst;

  // a requester waiting on its status is held off until it is taken
  assign elig = req_valid & ~resp_valid & {NREQ{mem_ready}};

  xm_arbiter #(.NREQ(NREQ)) i_arb (
    .req  (elig),
    .grant(grant),
    .gid  (gid),
    .any  (acc)
  );

  always_comb begin
    sel_op    = OP_LOAD;
    sel_addr  = '0;
    sel_wdata = '0;
    for (int i = 0; i < NREQ; i++) begin
      if (grant[i]) begin
        sel_op    = xm_op_e'(req_op[i*2 +: 2]);
        sel_addr  = req_addr[i*AW +: AW];
        sel_wdata = req_wdata[i*DW +: DW];
      end
    end
  end

  xm_resv_table #(.NREQ(NREQ), .TW(TW)) i_tbl (
    .clk    (clk),
    .rst_n  (rst_n),
    .acc    (acc),
    .gid    (gid),
    .op     (sel_op),
    .granule(sel_addr[AW-1:GB]),
    .own_hit(own_hit)
  );

  assign is_xst    = (sel_op == OP_XSTORE);
  assign req_ready = grant;
  assign mem_valid = acc && !(is_xst && !own_hit);
  assign mem_write = (sel_op == OP_STORE) || is_xst;
  assign mem_addr  = sel_addr;
  assign mem_wdata = sel_wdata;
  assign mem_id    = gid;

  xm_resp #(.NREQ(NREQ)) i_resp (
    .clk       (clk),
    .rst_n     (rst_n),
    .set       (grant & {NREQ{is_xst}}),
    .set_fail  (!own_hit),
    .resp_ready(resp_ready),
    .resp_valid(resp_valid),
    .resp_fail (resp_fail)
  );

  for (genvar i = 0; i < NREQ; i++) begin : g_chk
    assert_pass_writes_R2: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(resp_valid[i]) && !resp_fail[i])
      |-> $past(mem_valid && mem_write && (mem_id == IDW'(i))));

    assert_fail_silent_R3: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(resp_valid[i]) && resp_fail[i]) |-> !$past(mem_valid));

    assert_pending_blocks_R9: assert property (@(posedge clk) disable iff (!rst_n)
      resp_valid[i] |-> !req_ready[i]);
  end

  assert_single_accept_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(req_ready));

  assert_mem_stall_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_ready |-> (req_ready == '0));
endmodule

// File: tb/test_excl_resv_monitor.sv
`timescale 1ns/100ps
module test_excl_resv_monitor;
  localparam int N = 4;

  typedef struct packed {
    logic [1:0]  id;
    logic [1:0]  op;
    logic [31:0] addr;
    logic        em;
    logic        ef;
    logic [3:0]  rq;
  } vec_t;

  // id, op, addr, expect mem access, expect fail, requirement
  localparam int NV = 23;
  localparam vec_t VEC [NV] = '{
    '{2'd0, 2'd2, 32'h100, 1'b1, 1'b0, 4'd1},   // R1 reserve
    '{2'd0, 2'd3, 32'h108, 1'b1, 1'b0, 4'd2},   // R2 / R4 same granule
    '{2'd0, 2'd3, 32'h100, 1'b0, 1'b1, 4'd6},   // R6 cleared by last store
    '{2'd1, 2'd3, 32'h200, 1'b0, 1'b1, 4'd3},   // R3 no reservation
    '{2'd1, 2'd2, 32'h200, 1'b1, 1'b0, 4'd1},
    '{2'd2, 2'd0, 32'h200, 1'b1, 1'b0, 4'd11},  // R11 plain load
    '{2'd2, 2'd1, 32'h300, 1'b1, 1'b0, 4'd7},   // R7 other granule
    '{2'd1, 2'd3, 32'h20C, 1'b1, 1'b0, 4'd4},   // R4 survives
    '{2'd2, 2'd2, 32'h400, 1'b1, 1'b0, 4'd1},
    '{2'd3, 2'd1, 32'h404, 1'b1, 1'b0, 4'd7},   // R7 foreign store
    '{2'd2, 2'd3, 32'h400, 1'b0, 1'b1, 4'd7},
    '{2'd3, 2'd2, 32'h500, 1'b1, 1'b0, 4'd5},   // R5
    '{2'd3, 2'd2, 32'h600, 1'b1, 1'b0, 4'd5},
    '{2'd3, 2'd3, 32'h500, 1'b0, 1'b1, 4'd5},
    '{2'd3, 2'd2, 32'h600, 1'b1, 1'b0, 4'd5},
    '{2'd3, 2'd3, 32'h610, 1'b0, 1'b1, 4'd3},   // R3 wrong granule
    '{2'd0, 2'd2, 32'h700, 1'b1, 1'b0, 4'd1},
    '{2'd0, 2'd1, 32'h700, 1'b1, 1'b0, 4'd11},  // R11 own store
    '{2'd0, 2'd3, 32'h700, 1'b1, 1'b0, 4'd11},
    '{2'd1, 2'd2, 32'h800, 1'b1, 1'b0, 4'd1},
    '{2'd2, 2'd2, 32'h800, 1'b1, 1'b0, 4'd1},
    '{2'd2, 2'd3, 32'h800, 1'b1, 1'b0, 4'd7},
    '{2'd1, 2'd3, 32'h800, 1'b0, 1'b1, 4'd7}    // R7 broken by success
  };

  logic           clk = 1'b0;
  logic           rst_n;
  logic [N-1:0]   req_valid;
  logic [2*N-1:0] req_op;
  logic [32*N-1:0] req_addr;
  logic [32*N-1:0] req_wdata;
  logic [N-1:0]   req_ready;
  logic           mem_valid;
  logic           mem_write;
  logic [31:0]    mem_addr;
  logic [31:0]    mem_wdata;
  logic [1:0]     mem_id;
  logic           mem_ready;
  logic [N-1:0]   resp_valid;
  logic [N-1:0]   resp_fail;
  logic [N-1:0]   resp_ready;

  int n_chk = 0;
  int n_fail = 0;

  always #2.5 clk = ~clk;

  excl_resv_monitor #(.NREQ(N), .AW(32), .DW(32), .GB(4)) i_excl_resv_monitor (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_op(req_op), .req_addr(req_addr), .req_wdata(req_wdata),
    .req_ready(req_ready),
    .mem_valid(mem_valid), .mem_write(mem_write), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_id(mem_id), .mem_ready(mem_ready),
    .resp_valid(resp_valid), .resp_fail(resp_fail), .resp_ready(resp_ready)
  );

  task automatic check(input bit ok, input int rq, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL R%0d actual=%h expected=%h", rq, act, exp);
    end
  endtask

  task automatic set_req(input int id, input logic [1:0] op, input logic [31:0] addr);
    req_valid[id]          = 1'b1;
    req_op[id*2 +: 2]      = op;
    req_addr[id*32 +: 32]  = addr;
    req_wdata[id*32 +: 32] = ~addr;
  endtask

  task automatic run_vec(input vec_t v, input bit chk);
    @(negedge clk);
    set_req(int'(v.id), v.op, v.addr);
    #1;
    if (chk) begin
      check(mem_valid === v.em, int'(v.rq), 64'(mem_valid), 64'(v.em));
      if (v.em)
        check(mem_id === v.id && mem_addr === v.addr && mem_write === v.op[0],
              int'(v.rq), {29'd0, mem_write, mem_id, mem_addr}, {29'd0, v.op[0], v.id, v.addr});
    end
    @(posedge clk);
    #1;
    if (chk) begin
      if (v.op == 2'd3)  // R2 R3 status
        check(resp_valid[v.id] === 1'b1 && resp_fail[v.id] === v.ef, int'(v.rq),
              {62'd0, resp_valid[v.id], resp_fail[v.id]}, {62'd0, 1'b1, v.ef});
      else               // R9 no status for other ops
        check(resp_valid[v.id] === 1'b0, 9, 64'(resp_valid[v.id]), 64'd0);
    end
    @(negedge clk);
    req_valid = '0;
  endtask

  task automatic summary;
    $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    rst_n      = 1'b0;
    req_valid  = '0;
    req_op     = '0;
    req_addr   = '0;
    req_wdata  = '0;
    mem_ready  = 1'b1;
    resp_ready = '1;
    repeat (3) @(negedge clk);
    // R10 reset state
    check(mem_valid === 1'b0 && resp_valid === '0, 10, {59'd0, mem_valid, resp_valid}, 64'd0);
    rst_n = 1'b1;

    for (int k = 0; k < NV; k++) run_vec(VEC[k], 1'b1);

    // R11 memory back-pressure
    @(negedge clk);
    mem_ready = 1'b0;
    set_req(0, 2'd0, 32'h40);
    #1;
    check(req_ready === 4'b0000 && mem_valid === 1'b0, 11, {59'd0, mem_valid, req_ready}, 64'd0);
    @(negedge clk);
    mem_ready = 1'b1;
    #1;
    check(req_ready === 4'b0001 && mem_valid === 1'b1, 11, {59'd0, mem_valid, req_ready}, 64'h11);
    @(negedge clk);
    req_valid = '0;

    // R8 simultaneous exclusive stores to one granule
    run_vec('{2'd0, 2'd2, 32'hA00, 1'b1, 1'b0, 4'd8}, 1'b0);
    run_vec('{2'd1, 2'd2, 32'hA04, 1'b1, 1'b0, 4'd8}, 1'b0);
    @(negedge clk);
    set_req(0, 2'd3, 32'hA00);
    set_req(1, 2'd3, 32'hA08);
    #1;
    check(req_ready === 4'b0001 && mem_valid === 1'b1, 8, {59'd0, mem_valid, req_ready}, 64'h11);
    @(posedge clk);
    #1;
    check(resp_valid[0] === 1'b1 && resp_fail[0] === 1'b0, 8, {62'd0, resp_valid[0], resp_fail[0]}, 64'h2);
    @(negedge clk);
    req_valid[0] = 1'b0;
    #1;
    check(req_ready === 4'b0010 && mem_valid === 1'b0, 8, {59'd0, mem_valid, req_ready}, 64'h2);
    @(posedge clk);
    #1;
    check(resp_valid[1] === 1'b1 && resp_fail[1] === 1'b1, 8, {62'd0, resp_valid[1], resp_fail[1]}, 64'h3);
    @(negedge clk);
    req_valid = '0;

    // R9 status held until taken, requester blocked meanwhile
    run_vec('{2'd2, 2'd2, 32'hB00, 1'b1, 1'b0, 4'd9}, 1'b0);
    @(negedge clk);
    resp_ready = 4'b1011;
    set_req(2, 2'd3, 32'hB00);
    @(posedge clk);
    #1;
    check(resp_valid[2] === 1'b1 && resp_fail[2] === 1'b0, 9, {62'd0, resp_valid[2], resp_fail[2]}, 64'h2);
    @(negedge clk);
    set_req(2, 2'd0, 32'hB00);
    for (int k = 0; k < 3; k++) begin
      #1;
      check(req_ready[2] === 1'b0 && resp_valid[2] === 1'b1 && resp_fail[2] === 1'b0, 9,
            {61'd0, req_ready[2], resp_valid[2], resp_fail[2]}, 64'h2);
      @(negedge clk);
    end
    req_valid  = '0;
    resp_ready = '1;
    @(posedge clk);
    #1;
    check(resp_valid[2] === 1'b0, 9, 64'(resp_valid[2]), 64'd0);

    // R10 reset drops a live reservation
    run_vec('{2'd0, 2'd2, 32'h900, 1'b1, 1'b0, 4'd10}, 1'b0);
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    run_vec('{2'd0, 2'd3, 32'h900, 1'b0, 1'b1, 4'd10}, 1'b1);

    @(negedge clk);
    summary();
    $finish;
  end
endmodule